// File: doc/BRIEF.md
# Reference Clock Supervisor with Band Detection and Switchover

This block supervises the reference input of a clock-multiplier loop. It takes a primary clock and a backup clock, and it measures each one against a fixed window of a free-running system clock. Every measurement is sorted into one of six frequency bands spaced an octave apart, or rejected when it lies between or outside them. From this the block decides whether the primary may be trusted. It drives the reference select and a power-of-two ratio exponent that keeps the loop output in the range chosen by `range_hi`. It also drives an active-low lock flag.

Each input has its own edge counter in that input's clock domain. At every window boundary the system side flips a request toggle. The input side synchronises the toggle with two flops, snapshots its edge count and flips an acknowledge toggle back. The snapshot is read once that acknowledge has passed its own two-flop synchroniser. If windows keep ending with no acknowledge, a dead input is detected without waiting for a count.

A five-state machine owns the select. `ST_ACQ` is the start-up state and waits for the primary. It goes to `ST_PRI` after three consecutive in-band primary windows. It goes to `ST_TO_BAK` when the primary fails and the backup is not itself lost. `ST_PRI` also goes to `ST_TO_BAK` when the primary fails. `ST_TO_BAK` lasts one cycle and always goes to `ST_BAK`. `ST_BAK` goes to `ST_TO_PRI` after three consecutive in-band primary windows. `ST_TO_PRI` lasts one cycle and always goes to `ST_PRI`. The two one-cycle states raise the hold-over pulse, and the select changes on the cycle after that pulse.

Top module: `clkmon_switch`

## Requirements
- R1: While reset is held and right after it is released, `use_bak` is 0, `lock_n` is 1 and `holdover` is 0.
- R2: With window counts per band k (0..5) of [BAND0_LO<<k, BAND0_HI<<k] (default 56..72 at k=0), a count inside one of them selects band k. A count outside all six bands is invalid.
- R3: `ratio_exp` is a 4-bit two's-complement value equal to T minus k. T is 3 when `range_hi` is 0 and 5 when it is 1. k is the last in-band band of the source currently selected.
- R4: `lock_n` is 0 only in state `ST_PRI` when the latest in-band primary count lies in the inner window [CTR0_LO<<k, CTR0_HI<<k] (default 62..66 at k=0). Otherwise it is 1, including when the primary drifts toward a band edge, and the block stays on the primary.
- R5: The primary is declared lost after two consecutive window boundaries with no completed measurement, and not earlier. Losing it while on the primary starts a switch to the backup.
- R6: A primary measurement that is invalid (R2) while the primary is selected starts a switch to the backup.
- R7: `holdover` is never high for two cycles in a row. `use_bak` changes only in the cycle after `holdover` was high.
- R8: While on the backup, `ratio_exp` follows the backup's own band. The ratio is updated one window after the backup changes band.
- R9: The block returns to the primary, or first selects it from start-up, only after three consecutive in-band primary windows. It does not return earlier.
- R10: `lock_n` is 1 whenever `use_bak` is 1.
- R11: The block leaves the start-up or primary states for the backup only while the backup is not itself declared lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock that defines the measurement windows |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_clk | input | 1 | Primary reference clock being supervised |
| bak_clk | input | 1 | Backup reference clock |
| range_hi | input | 1 | Output range choice: 0 selects the lower target band, 1 the upper |
| use_bak | output | 1 | Reference select: 0 primary, 1 backup |
| holdover | output | 1 | One-cycle request for the loop to hold its frequency while the select moves |
| lock_n | output | 1 | Low only while locked to a well-centred primary |
| ratio_exp | output | 4 | Signed power-of-two ratio exponent for the loop divider |

## Verification
The assertions assume that `range_hi` changes only away from system-clock edges. They also assume that the monitored clocks, whenever running, stay inside the counter range, so that a saturated count is always a rejected one. The bench meets both conditions. It drives the mode from the negative system edge, and it runs every input clock at a fixed period chosen so that the nominal count sits on a band centre, near the edge of a band, or in the gap between two bands. Period changes are followed by enough windows for any mixed-period window to pass out of the history before results are sampled.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
    localparam int NBANDS = 6;
    localparam int BAND_W = $clog2(NBANDS);
    localparam int RATIO_W = BAND_W + 1;

    typedef enum logic [2:0] {
        ST_ACQ,
        ST_PRI,
        ST_TO_BAK,
        ST_BAK,
        ST_TO_PRI
    } sel_state_e;
endpackage

// File: rtl/clkmon_edge_meter.sv
`timescale 1ns/1ps
module clkmon_edge_meter #(
    parameter int CNT_W      = 13,
    parameter int MISS_LIMIT = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             meas_clk,
    input  logic             win_tick,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             lost
);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0] MISS_MAX = MW'(MISS_LIMIT);

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // measured-clock domain
    logic [2:0]       req_s;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic             ack_t;
    // system domain
    logic             req_t;
    logic [2:0]       ack_s;
    logic             pending;
    logic [MW-1:0]    miss;
    logic             ack_edge;

    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s    <= '0;
            run_cnt  <= '0;
            hold_cnt <= '0;
            ack_t    <= 1'b0;
        end else begin
            req_s <= {req_s[1:0], req_t};
            if (req_s[2] != req_s[1]) begin
                hold_cnt <= sat_inc(run_cnt);
                run_cnt  <= '0;
                ack_t    <= ~ack_t;
            end else begin
                run_cnt <= sat_inc(run_cnt);
            end
        end
    end

    assign ack_edge = ack_s[2] ^ ack_s[1];

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_s    <= '0;
            req_t    <= 1'b0;
            pending  <= 1'b0;
            miss     <= '0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            ack_s    <= {ack_s[1:0], ack_t};
            meas_vld <= ack_edge;
            if (ack_edge) begin
                meas_cnt <= hold_cnt;
                pending  <= 1'b0;
                miss     <= '0;
            end
            if (win_tick) begin
                if (pending && !ack_edge) begin
                    if (miss != MISS_MAX) miss <= miss + 1'b1;
                end else begin
                    req_t   <= ~req_t;
                    pending <= 1'b1;
                end
            end
        end
    end

    assign lost = (miss == MISS_MAX);
endmodule

// File: rtl/clkmon_band_classifier.sv
`timescale 1ns/1ps
module clkmon_band_classifier
    import clkmon_pkg::*;
#(
    parameter int CNT_W   = 13,
    parameter int BASE_LO = 56,
    parameter int BASE_HI = 72
) (
    input  logic [CNT_W-1:0]  cnt,
    output logic              inband,
    output logic [BAND_W-1:0] band
);
    logic [NBANDS-1:0] hit;

    for (genvar k = 0; k < NBANDS; k++) begin : g_band
        localparam logic [CNT_W-1:0] LO_K = CNT_W'(BASE_LO << k);
        localparam logic [CNT_W-1:0] HI_K = CNT_W'(BASE_HI << k);
        assign hit[k] = (cnt >= LO_K) && (cnt <= HI_K);
    end

    always_comb begin
        band = '0;
        for (int k = 0; k < NBANDS; k++) begin
            if (hit[k]) band = BAND_W'(k);
        end
    end

    assign inband = |hit;
endmodule

// File: rtl/clkmon_switch_fsm.sv
`timescale 1ns/1ps
module clkmon_switch_fsm
    import clkmon_pkg::*;
#(
    parameter int NEED_GOOD = 3,
    parameter int TGT_LO    = 3,
    parameter int TGT_HI    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               range_hi,
    input  logic               pri_vld,
    input  logic               pri_inband,
    input  logic               pri_centered,
    input  logic [BAND_W-1:0]  pri_band,
    input  logic               pri_lost,
    input  logic               bak_vld,
    input  logic               bak_inband,
    input  logic [BAND_W-1:0]  bak_band,
    input  logic               bak_lost,
    output logic               use_bak,
    output logic               holdover,
    output logic               lock_n,
    output logic [RATIO_W-1:0] ratio_exp
);
    localparam int GW = $clog2(NEED_GOOD + 1);
    localparam logic [GW-1:0] GOOD_MAX = GW'(NEED_GOOD);

    sel_state_e        state, state_n;
    logic [GW-1:0]     streak;
    logic [BAND_W-1:0] pri_band_q, bak_band_q;
    logic              pri_ctr_q;
    logic              pri_fail, pri_good, good_ok;
    logic [RATIO_W-1:0] tgt_v;
    logic [BAND_W-1:0]  sel_band;

    assign pri_fail = pri_lost | (pri_vld & ~pri_inband);
    assign pri_good = pri_vld & pri_inband;
    assign good_ok  = (streak == GOOD_MAX);

    // measurement history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            streak     <= '0;
            pri_band_q <= '0;
            bak_band_q <= '0;
            pri_ctr_q  <= 1'b0;
        end else begin
            if (pri_fail) streak <= '0;
            else if (pri_good && !good_ok) streak <= streak + 1'b1;
            if (pri_good) begin
                pri_band_q <= pri_band;
                pri_ctr_q  <= pri_centered;
            end
            if (bak_vld && bak_inband) bak_band_q <= bak_band;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACQ;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_ACQ: begin
                if (pri_fail && !bak_lost) state_n = ST_TO_BAK;
                else if (good_ok)          state_n = ST_PRI;
            end
            ST_PRI:    if (pri_fail && !bak_lost) state_n = ST_TO_BAK;
            ST_TO_BAK: state_n = ST_BAK;
            ST_BAK:    if (good_ok) state_n = ST_TO_PRI;
            ST_TO_PRI: state_n = ST_PRI;
            default:   state_n = ST_ACQ;
        endcase
    end

    // outputs
    always_comb begin
        use_bak  = 1'b0;
        holdover = 1'b0;
        lock_n   = 1'b1;
        unique case (state)
            ST_ACQ:    ;
            ST_PRI:    lock_n = ~pri_ctr_q;
            ST_TO_BAK: holdover = 1'b1;
            ST_BAK:    use_bak = 1'b1;
            ST_TO_PRI: begin
                use_bak  = 1'b1;
                holdover = 1'b1;
            end
            default:   ;
        endcase
        tgt_v     = range_hi ? RATIO_W'(TGT_HI) : RATIO_W'(TGT_LO);
        sel_band  = use_bak ? bak_band_q : pri_band_q;
        ratio_exp = tgt_v - {1'b0, sel_band};
    end
endmodule

// File: rtl/clkmon_switch.sv
`timescale 1ns/1ps
module clkmon_switch
    import clkmon_pkg::*;
#(
    parameter int WIN_CYCLES  = 1024,
    parameter int BAND0_LO    = 56,
    parameter int BAND0_HI    = 72,
    parameter int CTR0_LO     = 62,
    parameter int CTR0_HI     = 66,
    parameter int MISS_LIMIT  = 2,
    parameter int NEED_GOOD   = 3,
    parameter int TGT_LO_BAND = 3
) (
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic       pri_clk,
    input  logic       bak_clk,
    input  logic       range_hi,
    output logic       use_bak,
    output logic       holdover,
    output logic       lock_n,
    output logic [3:0] ratio_exp
);
    localparam int CNT_W = $clog2((BAND0_HI << (NBANDS - 1)) + 1) + 1;
    localparam int WW    = $clog2(WIN_CYCLES);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
    localparam int NSRC  = 2;

    logic [WW-1:0]    win_q;
    logic             win_tick;
    logic [NSRC-1:0]  src_clk;
    logic [NSRC-1:0]  m_vld, m_lost;
    logic [CNT_W-1:0] m_cnt [NSRC];

    logic              pri_inband, ctr_inband, bak_inband, pri_centered;
    logic [BAND_W-1:0] pri_band, ctr_band, bak_band;

    // window timer
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n)                win_q <= '0;
        else if (win_q == WIN_LAST) win_q <= '0;
        else                       win_q <= win_q + 1'b1;
    end
    assign win_tick = (win_q == WIN_LAST);

    assign src_clk = {bak_clk, pri_clk};

    for (genvar s = 0; s < NSRC; s++) begin : g_meter
        clkmon_edge_meter #(
            .CNT_W      (CNT_W),
            .MISS_LIMIT (MISS_LIMIT)
        ) u_meter (
            .sys_clk  (sys_clk),
            .rst_n    (rst_n),
            .meas_clk (src_clk[s]),
            .win_tick (win_tick),
            .meas_vld (m_vld[s]),
            .meas_cnt (m_cnt[s]),
            .lost     (m_lost[s])
        );
    end

    clkmon_band_classifier #(.CNT_W(CNT_W), .BASE_LO(BAND0_LO), .BASE_HI(BAND0_HI)) u_pri_cls (
        .cnt (m_cnt[0]), .inband (pri_inband), .band (pri_band));

    clkmon_band_classifier #(.CNT_W(CNT_W), .BASE_LO(CTR0_LO), .BASE_HI(CTR0_HI)) u_pri_ctr (
        .cnt (m_cnt[0]), .inband (ctr_inband), .band (ctr_band));

    clkmon_band_classifier #(.CNT_W(CNT_W), .BASE_LO(BAND0_LO), .BASE_HI(BAND0_HI)) u_bak_cls (
        .cnt (m_cnt[1]), .inband (bak_inband), .band (bak_band));

    assign pri_centered = ctr_inband && (ctr_band == pri_band);

    clkmon_switch_fsm #(
        .NEED_GOOD (NEED_GOOD),
        .TGT_LO    (TGT_LO_BAND),
        .TGT_HI    (NBANDS - 1)
    ) u_fsm (
        .clk          (sys_clk),
        .rst_n        (rst_n),
        .range_hi     (range_hi),
        .pri_vld      (m_vld[0]),
        .pri_inband   (pri_inband),
        .pri_centered (pri_centered),
        .pri_band     (pri_band),
        .pri_lost     (m_lost[0]),
        .bak_vld      (m_vld[1]),
        .bak_inband   (bak_inband),
        .bak_band     (bak_band),
        .bak_lost     (m_lost[1]),
        .use_bak      (use_bak),
        .holdover     (holdover),
        .lock_n       (lock_n),
        .ratio_exp    (ratio_exp)
    );
endmodule

// File: rtl/clkmon_switch_chk.sv
`timescale 1ns/1ps
module clkmon_switch_chk
    import clkmon_pkg::*;
#(
    parameter int TGT_LO_BAND = 3
) (
    input logic       sys_clk,
    input logic       rst_n,
    input logic       range_hi,
    input logic       use_bak,
    input logic       holdover,
    input logic       lock_n,
    input logic [3:0] ratio_exp,
    input logic       pri_vld,
    input logic       bak_vld,
    input logic       pri_lost,
    input logic       bak_lost
);
    p_sel_needs_hold_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !$stable(use_bak) |-> $past(holdover));

    p_hold_single_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        holdover |=> !holdover);

    p_lock_off_bak_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
        use_bak |-> lock_n);

    p_lock_needs_pri_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !lock_n |-> (!use_bak && !holdover));

    p_ratio_bounds_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ($signed(ratio_exp) >= $signed(5'(TGT_LO_BAND - (NBANDS - 1))))
        && ($signed(ratio_exp) <= $signed(5'(NBANDS - 1))));

    p_ratio_hold_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!$past(pri_vld) && !$past(bak_vld) && $stable(use_bak) && $stable(range_hi))
        |-> $stable(ratio_exp));

    p_loss_switch_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (pri_lost && !bak_lost && !use_bak && !holdover) |=> holdover);

    p_bak_alive_r11: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ($rose(holdover) && !use_bak) |-> !bak_lost);
endmodule

bind clkmon_switch clkmon_switch_chk #(.TGT_LO_BAND(TGT_LO_BAND)) u_chk (
    .sys_clk   (sys_clk),
    .rst_n     (rst_n),
    .range_hi  (range_hi),
    .use_bak   (use_bak),
    .holdover  (holdover),
    .lock_n    (lock_n),
    .ratio_exp (ratio_exp),
    .pri_vld   (m_vld[0]),
    .bak_vld   (m_vld[1]),
    .pri_lost  (m_lost[0]),
    .bak_lost  (m_lost[1])
);

// File: tb/clkmon_switch_tb.sv
`timescale 1ns/1ps
module clkmon_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 1024;
    // band-0 nominal count 64 over WIN*CLK_PERIOD ns -> 160 ns period
    localparam real BASE_HALF = 80.0;

    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic pri_clk = 1'b0;
    logic bak_clk = 1'b0;
    logic range_hi = 1'b0;
    logic use_bak, holdover, lock_n;
    logic [3:0] ratio_exp;

    real pri_half = 10.0;
    real bak_half = 20.0;
    logic pri_run = 1'b0;
    logic bak_run = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    clkmon_switch u_dut (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .pri_clk   (pri_clk),
        .bak_clk   (bak_clk),
        .range_hi  (range_hi),
        .use_bak   (use_bak),
        .holdover  (holdover),
        .lock_n    (lock_n),
        .ratio_exp (ratio_exp)
    );

    always #(CLK_PERIOD / 2) sys_clk = ~sys_clk;

    initial begin
        #3.3;
        forever begin
            #(pri_half);
            if (pri_run) pri_clk = ~pri_clk;
        end
    end

    initial begin
        #1.7;
        forever begin
            #(bak_half);
            if (bak_run) bak_clk = ~bak_clk;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_win(input real n);
        repeat (int'(n * WIN)) @(negedge sys_clk);
    endtask

    function automatic int ratio_now();
        return int'($signed(ratio_exp));
    endfunction

    // R7: select moves only after a single-cycle hold-over pulse
    logic prev_hold = 1'b0;
    logic prev_bak  = 1'b0;
    int   hold_pulses = 0;
    always @(negedge sys_clk) begin
        if (rst_n) begin
            if (holdover) hold_pulses++;
            if (holdover && prev_hold) chk("R7 double pulse", 1, 0);
            if (use_bak != prev_bak) chk("R7 select after hold", int'(prev_hold), 1);
        end
        prev_hold = holdover;
        prev_bak  = use_bak;
    end

    initial begin
        repeat (190000) @(posedge sys_clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int pulses0;
        // R1 reset state
        repeat (20) @(negedge sys_clk);
        chk("R1 use_bak in reset", int'(use_bak), 0);
        chk("R1 lock_n in reset", int'(lock_n), 1);
        chk("R1 holdover in reset", int'(holdover), 0);
        rst_n = 1'b1;
        @(negedge sys_clk);
        chk("R1 use_bak after reset", int'(use_bak), 0);
        chk("R1 lock_n after reset", int'(lock_n), 1);

        // R11: both inputs dead, no move to backup
        wait_win(4.5);
        chk("R11 stay with dead backup", int'(use_bak), 0);
        chk("R11 lock_n dead", int'(lock_n), 1);
        // backup comes alive (band 2), primary still dead -> switch
        bak_run = 1'b1;
        wait_win(2.0);
        chk("R11 switch once backup alive", int'(use_bak), 1);
        chk("R10 lock_n on backup", int'(lock_n), 1);

        // R9 acquisition of primary at band 3
        pri_run = 1'b1;
        wait_win(0.5);
        chk("R9 not yet back", int'(use_bak), 1);
        wait_win(6.0);
        chk("R9 on primary", int'(use_bak), 0);
        chk("R4 locked centred", int'(lock_n), 0);
        chk("R3 ratio band3 low", ratio_now(), 0);

        // R2/R3 sweep over all bands and both ranges
        for (int b = 0; b < 6; b++) begin
            pri_half = BASE_HALF / real'(1 << b);
            wait_win(6.0);
            for (int m = 0; m < 2; m++) begin
                range_hi = m[0];
                repeat (2) @(negedge sys_clk);
                chk($sformatf("R2 R3 band %0d mode %0d ratio", b, m), ratio_now(), (m == 1 ? 5 : 3) - b);
                chk($sformatf("R2 band %0d on primary", b), int'(use_bak), 0);
                chk($sformatf("R4 band %0d lock_n", b), int'(lock_n), 0);
            end
        end

        // R4 drift toward the band-0 upper edge: count about 69
        range_hi = 1'b0;
        pri_half = 74.2;
        wait_win(6.0);
        chk("R4 drift lock_n high", int'(lock_n), 1);
        chk("R4 drift stays primary", int'(use_bak), 0);
        chk("R2 R3 drift band0 ratio", ratio_now(), 3);

        // back to centred band 4, high range
        pri_half = 5.0;
        range_hi = 1'b1;
        wait_win(6.0);
        chk("R4 relock centred", int'(lock_n), 0);
        chk("R3 band4 high ratio", ratio_now(), 1);

        // R5 loss of primary
        pulses0 = hold_pulses;
        pri_run = 1'b0;
        wait_win(1.5);
        chk("R5 not lost after one empty window", int'(use_bak), 0);
        wait_win(2.0);
        chk("R5 switched after loss", int'(use_bak), 1);
        chk("R10 lock_n on backup", int'(lock_n), 1);
        chk("R8 ratio from backup band2", ratio_now(), 3);
        chk("R7 one hold pulse for switch", hold_pulses - pulses0, 1);

        // R9 return with hysteresis
        pri_run = 1'b1;
        wait_win(0.5);
        chk("R9 still backup shortly after return", int'(use_bak), 1);
        wait_win(6.0);
        chk("R9 back on primary", int'(use_bak), 0);
        chk("R4 lock after return", int'(lock_n), 0);
        chk("R3 ratio after return", ratio_now(), 1);

        // R6 primary in the gap between band 0 and band 1 (count about 90)
        range_hi = 1'b0;
        pri_half = 56.9;
        wait_win(3.0);
        chk("R6 gap frequency to backup", int'(use_bak), 1);
        chk("R10 lock_n gap", int'(lock_n), 1);
        chk("R8 low range backup ratio", ratio_now(), 1);

        // R8 backup moves to band 0
        bak_half = 80.0;
        wait_win(3.0);
        chk("R8 backup band0 low", ratio_now(), 3);
        range_hi = 1'b1;
        repeat (2) @(negedge sys_clk);
        chk("R8 backup band0 high", ratio_now(), 5);

        // primary returns at band 1
        pri_half = 40.0;
        wait_win(6.0);
        chk("R9 primary band1", int'(use_bak), 0);
        chk("R3 band1 high ratio", ratio_now(), 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule